// File: doc/BRIEF.md
# Camera Sensor Clock Generator

This block produces the clock that a parallel camera port sends out to its image sensor. It also supplies the enables that gate the port's own clocks. A 3-bit code selects the sensor clock. It divides the reference clock by one of seven ratios, and the code-to-ratio table does not run in order. The eighth code parks the output low.

An enable gates the sensor clock output. Another enable produces a clock enable for the port's internal logic. A third enable turns on pixel sampling. When sampling is on, the incoming pixel clock is synchronised into the reference domain. The block then emits a one-cycle strobe on the rising edge of the pixel clock, or on the falling edge, as a polarity bit selects.

All controls arrive on one 8-bit control word, with these bit positions:

| Bit | Function |
|-----|----------|
| 7 | Pixel sampling enable |
| 5 | Internal clock enable |
| 4 | Sensor clock enable |
| 3 | Sampling polarity |
| 2:0 | Divide code |

Top module: `camclk_gen`

## Requirements
- R1: While reset is asserted and right after it, `sens_clk`, `core_clk_en` and `pix_stb` are all 0.
- R2: The divide code in `ctrl[2:0]` sets the `sens_clk` period in reference cycles: code 0→8, 1→3, 2→16, 3→2, 4→10, 5→4, 6→12.
- R3: For an even ratio N, `sens_clk` is high for N/2 cycles and low for N/2 cycles. For ratio 3, it is high for 1 cycle and low for 2 cycles.
- R4: Divide code 7 holds `sens_clk` low, starting from the next reference edge.
- R5: When the sensor clock enable `ctrl[4]` is 0, `sens_clk` is held low, starting from the next reference edge.
- R6: A new divide code takes effect only at the next `sens_clk` rising edge. The period already under way finishes with its old high and low lengths.
- R7: `core_clk_en` follows the internal clock enable `ctrl[5]`, one reference cycle later.
- R8: When `ctrl[7]`=1 and polarity `ctrl[3]`=0, each rising edge of `pix_clk` gives exactly one `pix_stb` pulse, one cycle wide.
- R9: When `ctrl[7]`=1 and `ctrl[3]`=1, each falling edge of `pix_clk` gives exactly one one-cycle `pix_stb` pulse.
- R10: When `ctrl[7]`=0, `pix_clk` edges produce no `pix_stb` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Peripheral reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 8 | Control word (enables, polarity, divide code) |
| pix_clk | input | 1 | Pixel clock from the sensor, asynchronous |
| sens_clk | output | 1 | Divided sensor clock, registered |
| core_clk_en | output | 1 | Clock enable for the internal interface logic |
| pix_stb | output | 1 | One-cycle strobe on the selected pixel clock edge |

## Verification
The bench measures the high and low length of every ratio, including the odd ratio 3. A divider that rounded its half period the wrong way would give 2/1 there instead of 1/2. It switches the code in the middle of a long high phase. A design that reloaded at once would cut the current period short and emit a runt pulse instead of completing 8/8. It counts strobe pulses under both polarities and with sampling off. This catches an inverted polarity, a missing enable gate, or a strobe held for more than one cycle.

// File: rtl/camclk_gen.sv
module camclk_gen #(
  parameter int CNT_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [7:0] ctrl,
  input  logic       pix_clk,
  output logic       sens_clk,
  output logic       core_clk_en,
  output logic       pix_stb
);

  localparam logic [2:0] PARK_CODE = 3'd7;

  function automatic logic [CNT_W-1:0] ratio_of(input logic [2:0] code);
    case (code)
      3'd0:    ratio_of = CNT_W'(8);
      3'd1:    ratio_of = CNT_W'(3);
      3'd2:    ratio_of = CNT_W'(16);
      3'd3:    ratio_of = CNT_W'(2);
      3'd4:    ratio_of = CNT_W'(10);
      3'd5:    ratio_of = CNT_W'(4);
      3'd6:    ratio_of = CNT_W'(12);
      default: ratio_of = CNT_W'(8);
    endcase
  endfunction

  wire       pix_en   = ctrl[7];
  wire       core_en  = ctrl[5];
  wire       sens_en  = ctrl[4];
  wire       fall_sel = ctrl[3];
  wire [2:0] code     = ctrl[2:0];

  wire active = sens_en && (code != PARK_CODE);

  logic [CNT_W-1:0] cnt_q, div_q;
  logic             parked_q, sens_q;

  wire [CNT_W-1:0] half     = div_q >> 1;
  wire [CNT_W-1:0] cnt_next = cnt_q + 1'b1;
  wire             wrap     = parked_q || (cnt_q == div_q - 1'b1);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      div_q    <= CNT_W'(8);
      parked_q <= 1'b1;
      sens_q   <= 1'b0;
    end else if (!active) begin
      cnt_q    <= '0;
      parked_q <= 1'b1;
      sens_q   <= 1'b0;
    end else if (wrap) begin
      cnt_q    <= '0;
      div_q    <= ratio_of(code);
      parked_q <= 1'b0;
      sens_q   <= 1'b1;
    end else begin
      cnt_q <= cnt_next;
      if (cnt_next == half) sens_q <= 1'b0;
    end
  end

  assign sens_clk = sens_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) core_clk_en <= 1'b0;
    else        core_clk_en <= core_en;
  end

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q, stb_q;

  wire pix_s    = sync_q[SYNC_STAGES-1];
  wire pix_rise = pix_s && !prev_q;
  wire pix_fall = !pix_s && prev_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pix_clk};
      prev_q <= pix_s;
      stb_q  <= pix_en && (fall_sel ? pix_fall : pix_rise);
    end
  end

  assign pix_stb = stb_q;

endmodule

module camclk_gen_chk (
  input logic       clk_ref,
  input logic       rst_n,
  input logic [7:0] ctrl,
  input logic       sens_clk,
  input logic       core_clk_en,
  input logic       pix_stb
);

  // R1
  always_comb if (!rst_n) begin
    reset_quiet_chk: assert (!sens_clk && !core_clk_en && !pix_stb);
  end

  // R4
  park_code_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (ctrl[2:0] == 3'd7) |=> !sens_clk);

  // R5
  sens_disabled_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !ctrl[4] |=> !sens_clk);

  // R7
  core_en_set_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ctrl[5] |=> core_clk_en);

  // R7
  core_en_clr_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !ctrl[5] |=> !core_clk_en);

  // R10
  stb_needs_enable_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !ctrl[7] |=> !pix_stb);

endmodule

bind camclk_gen camclk_gen_chk u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .ctrl(ctrl),
  .sens_clk(sens_clk), .core_clk_en(core_clk_en), .pix_stb(pix_stb)
);

// File: tb/camclk_gen_tb.sv
module camclk_gen_tb;

  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic [7:0] ctrl    = 8'h00;
  logic       pix_clk = 1'b0;
  logic       sens_clk, core_clk_en, pix_stb;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_ref = ~clk_ref;

  camclk_gen u_dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .ctrl(ctrl), .pix_clk(pix_clk),
    .sens_clk(sens_clk), .core_clk_en(core_clk_en), .pix_stb(pix_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_period(input int h0, output int hi, output int lo);
    hi = h0;
    lo = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_ref);
      if (!sens_clk) break;
      hi++;
    end
    for (int i = 0; i < 100; i++) begin
      if (sens_clk) break;
      lo++;
      @(negedge clk_ref);
    end
  endtask

  task automatic measure(output int hi, output int lo);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_ref);
      if (!sens_clk) break;
    end
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_ref);
      if (sens_clk) break;
    end
    count_period(1, hi, lo);
  endtask

  task automatic test_reset;
    @(negedge clk_ref);
    chk("R1 sens_clk in reset", int'(sens_clk), 0);
    chk("R1 core_clk_en in reset", int'(core_clk_en), 0);
    chk("R1 pix_stb in reset", int'(pix_stb), 0);
    rst_n = 1'b1;
    @(negedge clk_ref);
    chk("R1 sens_clk after reset", int'(sens_clk), 0);
    chk("R1 core_clk_en after reset", int'(core_clk_en), 0);
  endtask

  task automatic test_ratios;
    int exp_r[7] = '{8, 3, 16, 2, 10, 4, 12};
    int hi, lo;
    for (int c = 0; c < 7; c++) begin
      @(negedge clk_ref);
      ctrl = 8'h10 | 8'(c);
      measure(hi, lo);
      measure(hi, lo);
      chk($sformatf("R2 period code %0d", c), hi + lo, exp_r[c]);
      chk($sformatf("R3 high length code %0d", c), hi, exp_r[c] / 2);
      chk($sformatf("R3 low length code %0d", c), lo, exp_r[c] - exp_r[c] / 2);
    end
  endtask

  task automatic test_park;
    int highs = 0;
    @(negedge clk_ref);
    ctrl = 8'h17;
    @(negedge clk_ref);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_ref);
      if (sens_clk) highs++;
    end
    chk("R4 code 7 high samples", highs, 0);
    highs = 0;
    ctrl = 8'h00;
    @(negedge clk_ref);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_ref);
      if (sens_clk) highs++;
    end
    chk("R5 disabled high samples", highs, 0);
  endtask

  task automatic test_code_change;
    int hi, lo;
    @(negedge clk_ref);
    ctrl = 8'h12;
    measure(hi, lo);
    @(negedge clk_ref);
    @(negedge clk_ref);
    ctrl = 8'h13;
    count_period(3, hi, lo);
    chk("R6 old high phase kept", hi, 8);
    chk("R6 old low phase kept", lo, 8);
    count_period(1, hi, lo);
    chk("R6 new period high", hi, 1);
    chk("R6 new period low", lo, 1);
  endtask

  task automatic test_core_en;
    @(negedge clk_ref);
    ctrl = 8'h20;
    @(negedge clk_ref);
    chk("R7 core_clk_en set", int'(core_clk_en), 1);
    ctrl = 8'h00;
    @(negedge clk_ref);
    chk("R7 core_clk_en clear", int'(core_clk_en), 0);
  endtask

  task automatic pix_run(input logic [7:0] cw, output int pulses, output int hcyc);
    logic last = 1'b0;
    pulses = 0;
    hcyc = 0;
    @(negedge clk_ref);
    ctrl = cw;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_ref);
      if (i < 48 && i % 6 == 0) pix_clk = ~pix_clk;
      if (pix_stb) hcyc++;
      if (pix_stb && !last) pulses++;
      last = pix_stb;
    end
  endtask

  task automatic test_pix;
    int p, h;
    pix_run(8'h80, p, h);
    chk("R8 rising-edge pulses", p, 4);
    chk("R8 strobe high cycles", h, 4);
    pix_run(8'h88, p, h);
    chk("R9 falling-edge pulses", p, 4);
    chk("R9 strobe high cycles", h, 4);
    pix_run(8'h00, p, h);
    chk("R10 pulses with sampling off", p, 0);
    pix_run(8'h08, p, h);
    chk("R10 pulses off, falling polarity", p, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_ref);
    test_reset();
    test_ratios();
    test_park();
    test_code_change();
    test_core_en();
    test_pix();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_ref);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule